// File: doc/BRIEF.md
# Serial programming host sequencer

This block is the programmer-side controller that reads a byte-addressed target memory over a two-wire serial programming link. Software gives it a 22-bit start address, a byte count and a turnaround delay, then pulses `start`. The block first shifts six core instructions into the target. These load the target's table pointer one byte at a time. It then issues one table-read-with-post-increment command per requested byte. Each byte it receives comes out as a one-cycle `rd_valid` strobe with `rd_data`.

The serial clock is made from the system clock. Each serial bit lasts `2*HALF` system cycles: the clock is high for `HALF` cycles and then low for `HALF` cycles. The data pin is a tri-state, split into `sdata_o`, `sdata_oe` and `sdata_i`. During a read, the host releases the pin after the operand bits. It then holds the clock low for the programmed number of turnaround cycles and clocks in the returned byte. The target advances its own pointer after each read, so later bytes need no new address load.

Top module: `serprog_read_host`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `sclk_o`, `sdata_oe` and `rd_valid` are 0.
- R2: An accepted start first sends six instructions. Each is a 4-bit command of 0000 followed by a 16-bit opcode, every field sent least significant bit first, with `sdata_oe`=1. The opcodes are 0x0E00 plus addr[21:16], then 0x6EF8, then 0x0E00 plus addr[15:8], then 0x6EF7, then 0x0E00 plus addr[7:0], then 0x6EF6.
- R3: Every serial bit holds `sclk_o` high for `HALF` system cycles and then low for `HALF` cycles. `sdata_o` is stable for the whole bit. The first high cycle is the cycle right after the edge that accepts `start`.
- R4: Each byte read begins with command 1001, sent as bits 1,0,0,1. Eight operand bits follow, driven as 0 with `sdata_oe`=1.
- R5: After the last operand bit, `sdata_oe` is 0 and `sclk_o` is 0 for `turn_delay` system cycles. This value is captured at start. A value of 0 gives no turnaround cycles.
- R6: Eight read bits follow with `sdata_oe`=0. `sdata_i` is sampled on the last high cycle of each bit, and the first bit becomes bit 0 of the byte. The cycle after the last read bit's low phase carries `rd_valid`=1 for exactly one cycle, with the byte on `rd_data`.
- R7: `byte_count` bytes are read back to back with no further pointer load. The next read command starts in the cycle after `rd_valid`.
- R8: `busy` rises in the cycle after an accepted start and stays high through the last `rd_valid` cycle. It is low in the following cycle.
- R9: A `start` pulse while `busy` is high has no effect on the sequence in progress.
- R10: A `start` pulse with `byte_count`=0 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read sequence (accepted only when idle) |
| start_addr | input | 22 | First target byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| turn_delay | input | TURN_W | Turnaround cycles with the pin released and the clock low |
| busy | output | 1 | Sequence in progress |
| sclk_o | output | 1 | Serial clock to the target |
| sdata_o | output | 1 | Serial data driven toward the target |
| sdata_oe | output | 1 | Drive enable for the data pin |
| sdata_i | input | 1 | Serial data returned by the target |
| rd_valid | output | 1 | One-cycle strobe for a received byte |
| rd_data | output | 8 | Received byte |

## Verification
The bench builds the full expected waveform from the requirements before each sequence starts. `sclk_o`, `sdata_oe` and `busy` are due one cycle after the accepting edge. Setup lasts 120 bits of `2*HALF` cycles each, then each byte takes 20 bits plus the turnaround cycles. `rd_valid` arrives one cycle after the eighth read bit ends. Outputs are compared on every falling edge of the system clock against the entry for that cycle. The same entry supplies the target's reply bit on `sdata_i`, so the reply is already in place at the sampling edge. Start pulses sent while busy and start pulses with a zero count are applied during the compared cycles, so any effect they have shows up as a mismatch.

// File: rtl/serprog_read_host.sv
module serprog_read_host #(
  parameter int HALF   = 2,
  parameter int CNT_W  = 16,
  parameter int TURN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [21:0]       start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [TURN_W-1:0] turn_delay,
  output logic              busy,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe,
  input  logic              sdata_i,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam int CW = (2 * HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(2 * HALF - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF);
  localparam logic [CW-1:0] SAMP = CW'(HALF - 1);
  localparam logic [3:0]    CMD_RD = 4'b1001;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CMD, S_OPER, S_TURN, S_READ, S_DONE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [4:0]        bidx;
  logic [2:0]        ins;
  logic [21:0]       addr_q;
  logic [CNT_W-1:0]  rem;
  logic [TURN_W-1:0] turn_q, tcnt;
  logic [7:0]        shreg;
  logic [15:0]       opc;
  logic [4:0]        last_bit;
  logic              bit_st, setup_bit;

  always_comb begin
    case (ins)
      3'd0:    opc = {8'h0E, 2'b00, addr_q[21:16]};
      3'd1:    opc = 16'h6EF8;
      3'd2:    opc = {8'h0E, addr_q[15:8]};
      3'd3:    opc = 16'h6EF7;
      3'd4:    opc = {8'h0E, addr_q[7:0]};
      default: opc = 16'h6EF6;
    endcase
  end

  assign setup_bit = (bidx < 5'd4) ? 1'b0 : opc[4'(bidx - 5'd4)];
  assign bit_st    = (st == S_SETUP) || (st == S_CMD) || (st == S_OPER) || (st == S_READ);
  assign last_bit  = (st == S_SETUP) ? 5'd19 : (st == S_CMD) ? 5'd3 : 5'd7;

  assign busy     = (st != S_IDLE);
  assign sclk_o   = bit_st && (cnt < MID);
  assign sdata_oe = (st == S_SETUP) || (st == S_CMD) || (st == S_OPER);
  assign sdata_o  = (st == S_SETUP) ? setup_bit : (st == S_CMD) ? CMD_RD[bidx[1:0]] : 1'b0;
  assign rd_valid = (st == S_DONE);
  assign rd_data  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      ins    <= '0;
      addr_q <= '0;
      rem    <= '0;
      turn_q <= '0;
      tcnt   <= '0;
      shreg  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start && byte_count != '0) begin
            addr_q <= start_addr;
            rem    <= byte_count;
            turn_q <= turn_delay;
            cnt    <= '0;
            bidx   <= '0;
            ins    <= '0;
            st     <= S_SETUP;
          end
        end
        S_SETUP, S_CMD, S_OPER, S_READ: begin
          if (st == S_READ && cnt == SAMP)
            shreg[bidx[2:0]] <= sdata_i;
          if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (bidx != last_bit) begin
              bidx <= bidx + 1'b1;
            end else begin
              bidx <= '0;
              case (st)
                S_SETUP: if (ins != 3'd5) ins <= ins + 1'b1; else st <= S_CMD;
                S_CMD:   st <= S_OPER;
                S_OPER: begin
                  tcnt <= '0;
                  st   <= (turn_q == '0) ? S_READ : S_TURN;
                end
                default: st <= S_DONE;
              endcase
            end
          end
        end
        S_TURN: begin
          if (tcnt == turn_q - 1'b1) st <= S_READ;
          else tcnt <= tcnt + 1'b1;
        end
        default: begin
          if (rem == CNT_W'(1)) begin
            st <= S_IDLE;
          end else begin
            rem <= rem - 1'b1;
            st  <= S_CMD;
          end
        end
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk_o && !sdata_oe && !rd_valid)); // R1
  AST_BIT_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |=> (!sclk_o || $stable(sdata_o))); // R3
  AST_TURN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TURN) |-> (!sclk_o && !sdata_oe)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && byte_count != '0) |=> busy); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(addr_q) && $stable(turn_q))); // R9
  AST_ZERO_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && byte_count == '0) |=> !busy); // R10
endmodule

// File: tb/serprog_read_host_bench.sv
module serprog_read_host_bench;
  localparam int HALF = 2;
  logic clk = 0, rst_n = 0, start = 0, sdata_i = 0;
  logic [21:0] start_addr = '0;
  logic [15:0] byte_count = '0;
  logic [7:0]  turn_delay = '0;
  logic busy, sclk_o, sdata_o, sdata_oe, rd_valid;
  logic [7:0] rd_data;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serprog_read_host #(.HALF(HALF), .CNT_W(16), .TURN_W(8)) u_serprog_read_host (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .turn_delay(turn_delay), .busy(busy),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(sdata_i),
    .rd_valid(rd_valid), .rd_data(rd_data));

  bit q_sck[$], q_oe[$], q_do[$], q_busy[$], q_vld[$], q_sdi[$];
  logic [7:0] q_dat[$];
  string q_tag[$];

  function automatic logic [7:0] tgt(input logic [21:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic void push(bit sck, bit oe, bit d, bit b, bit v, logic [7:0] dat, bit sdi, string tag);
    q_sck.push_back(sck); q_oe.push_back(oe); q_do.push_back(d); q_busy.push_back(b);
    q_vld.push_back(v); q_dat.push_back(dat); q_sdi.push_back(sdi); q_tag.push_back(tag);
  endfunction

  function automatic void slot(bit oe, bit d, bit sdi, string tag);
    for (int h = 0; h < 2 * HALF; h++) push(h < HALF, oe, d, 1, 0, 8'h00, sdi, tag);
  endfunction

  function automatic void build(logic [21:0] addr, int cnt, int turn);
    logic [15:0] op [6];
    op[0] = {8'h0E, 2'b00, addr[21:16]}; op[1] = 16'h6EF8;
    op[2] = {8'h0E, addr[15:8]};         op[3] = 16'h6EF7;
    op[4] = {8'h0E, addr[7:0]};          op[5] = 16'h6EF6;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 20; b++) slot(1, (b < 4) ? 1'b0 : op[i][b-4], 0, "R2,R3");
    for (int k = 0; k < cnt; k++) begin
      logic [7:0] v;
      v = tgt(addr + 22'(k));
      slot(1, 1, 0, "R4,R7"); slot(1, 0, 0, "R4"); slot(1, 0, 0, "R4"); slot(1, 1, 0, "R4");
      for (int b = 0; b < 8; b++) slot(1, 0, 0, "R4,R3");
      for (int t = 0; t < turn; t++) push(0, 0, 0, 1, 0, 8'h00, 0, "R5");
      for (int b = 0; b < 8; b++) slot(0, 0, v[b], "R6");
      push(0, 0, 0, 1, 1, v, 0, "R6,R7");
    end
    push(0, 0, 0, 0, 0, 8'h00, 0, "R8");
  endfunction

  task automatic compare_now();
    bit bad;
    n_cmp++;
    bad = (sclk_o !== q_sck[0]) || (sdata_oe !== q_oe[0]) || (busy !== q_busy[0]) ||
          (rd_valid !== q_vld[0]) || (q_oe[0] && sdata_o !== q_do[0]) ||
          (q_vld[0] && rd_data !== q_dat[0]);
    if (bad) begin
      n_bad++;
      $display("FAIL %s @%0t: got sclk=%b oe=%b do=%b busy=%b vld=%b data=%h exp sclk=%b oe=%b do=%b busy=%b vld=%b data=%h",
               q_tag[0], $time, sclk_o, sdata_oe, sdata_o, busy, rd_valid, rd_data,
               q_sck[0], q_oe[0], q_do[0], q_busy[0], q_vld[0], q_dat[0]);
    end
    void'(q_sck.pop_front()); void'(q_oe.pop_front()); void'(q_do.pop_front());
    void'(q_busy.pop_front()); void'(q_vld.pop_front()); void'(q_dat.pop_front());
    void'(q_sdi.pop_front()); void'(q_tag.pop_front());
  endtask

  task automatic txn(logic [21:0] addr, int cnt, int turn, int poke);
    @(negedge clk);
    start = 1; start_addr = addr; byte_count = 16'(cnt); turn_delay = 8'(turn);
    @(negedge clk);
    start = 0;
    build(addr, cnt, turn);
    for (int i = 0; q_sck.size() > 0; i++) begin
      if (i > 0) @(negedge clk);
      start = 0;
      if (i == poke) begin  // R9: start while busy, different address and delay
        start = 1; start_addr = 22'h155555; byte_count = 16'd9; turn_delay = 8'd7;
      end
      sdata_i = q_sdi[0];
      compare_now();
    end
    start = 0; sdata_i = 0;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      push(0, 0, 0, 0, 0, 8'h00, 0, "R1"); compare_now();
    end
    rst_n = 1;
    @(negedge clk);
    push(0, 0, 0, 0, 0, 8'h00, 0, "R1"); compare_now();
    txn(22'h3FA5C3, 3, 3, -1);
    txn(22'h000010, 1, 0, 100);
    txn(22'h0123FE, 3, 5, 700);
    txn(22'h2A0F81, 2, 1, -1);
    @(negedge clk);
    start = 1; byte_count = 16'd0; start_addr = 22'h000001; turn_delay = 8'd2;  // R10
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = 0;
      push(0, 0, 0, 0, 0, 8'h00, 0, "R10"); compare_now();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule